// File: doc/BRIEF.md
# Ring Cellular-Automaton Pattern Generator

This block produces pseudo-random bit patterns by evolving a one-dimensional binary cellular automaton. The automaton has a configurable number of cells, 32 by default. Each cell is one flip-flop, and the cells form a closed ring. On every generation, all cells update together. A cell's new value is looked up in an 8-bit rule word, and the lookup index is the three-bit neighbourhood made of the cell's left neighbour, the cell itself and its right neighbour.

After reset the rule word holds rule 30, which gives chaotic evolution. The cell array resets to all zeros.

To use the block:
- Load a non-zero seed through the parallel load port.
- Request generations with the step input.
- Optionally write a different rule at any time.

The current cell array is driven straight onto the pattern output.

Top module: `ca_ring_prng`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the cell array clears to all zeros and the rule word returns to 8'h1E (rule 30). This holds even if a different rule was written before.
- R2: A cycle with `seed_load` high copies `seed_data` into the cell array. The copied value appears on `pattern` after that edge.
- R3: A cycle with `step_req` high and `seed_load` low advances the array by exactly one generation. Each new cell i equals rule bit number {L,S,R}, where L is the MSB of the index, L = cell (i+1) mod N, S = cell i, and R = cell (i−1) mod N. Bit 0 of `pattern` is cell 0.
- R4: The ring wraps. Cell N−1 takes cell 0 as its left neighbour, and cell 0 takes cell N−1 as its right neighbour. Under rule 30, the single-bit seed 32'h0000_0001 becomes 32'h8000_0003 after one step, and 32'h8000_0000 becomes 32'hC000_0001.
- R5: A cycle with both `seed_load` and `step_req` low leaves `pattern` unchanged.
- R6: When `seed_load` and `step_req` are both high, the load wins. `pattern` equals `seed_data` and no generation is applied.
- R7: A cycle with `rule_we` high captures `rule_data` as the rule word. A step in that same cycle still uses the previous rule, and steps in later cycles use the new rule.
- R8: Writing the rule on its own does not change `pattern`.
- R9: Under the reset rule, an all-zero array stays all zeros however many steps are requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| seed_load | input | 1 | Strobe that copies `seed_data` into the cells |
| seed_data | input | N_CELLS | Seed pattern |
| step_req | input | 1 | Advance one generation per cycle it is high |
| rule_we | input | 1 | Strobe that captures `rule_data` |
| rule_data | input | 8 | New rule word |
| pattern | output | N_CELLS | Current cell array |

## Verification
Every result is due exactly one rising edge after the cycle that asks for it:
- Loads, steps, holds and reset all show on `pattern` one edge after the request.
- A rule write first changes the generation computed at the edge after its own edge.

Stimulus is driven at the falling edge. The output is sampled 1 ns after each rising edge. At that same point the bench advances its reference model by one cycle, so every comparison lines up with the single register stage. The R7 checks place a step in the write cycle and another step in the cycle after it, so that both sides of the one-cycle rule latency are observed.

// File: rtl/ca_prng_pkg.sv
package ca_prng_pkg;

    localparam int unsigned RULE_W = 8;
    localparam logic [RULE_W-1:0] RULE_30 = 8'h1E;

    typedef logic [RULE_W-1:0] rule_t;

    // Operation applied to the cell array in one cycle
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } cell_op_e;

    // Three-cell neighbourhood seen by one cell
    typedef struct packed {
        logic left;
        logic self_b;
        logic right;
    } nbhd_t;

    function automatic logic apply_rule(input rule_t r, input nbhd_t n);
        return r[{n.left, n.self_b, n.right}];
    endfunction

    function automatic cell_op_e decode_op(input logic load, input logic step);
        if (load)
            return OP_LOAD;
        else if (step)
            return OP_STEP;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/ca_rule_reg.sv
module ca_rule_reg
    import ca_prng_pkg::*;
#(
    parameter rule_t RESET_RULE = RULE_30
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  rule_t din,
    output rule_t rule_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            rule_q <= RESET_RULE;
        else if (we)
            rule_q <= din;
    end

endmodule

// File: rtl/ca_next_gen.sv
module ca_next_gen
    import ca_prng_pkg::*;
#(
    parameter int unsigned N_CELLS = 32
) (
    input  logic [N_CELLS-1:0] cells,
    input  rule_t              rule,
    output logic [N_CELLS-1:0] next_cells
);

    localparam int unsigned LAST = N_CELLS - 1;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        localparam int unsigned LEFT_IDX  = (i == LAST) ? 0 : i + 1;
        localparam int unsigned RIGHT_IDX = (i == 0) ? LAST : i - 1;
        nbhd_t nb;
        always_comb begin
            nb.left   = cells[LEFT_IDX];
            nb.self_b = cells[i];
            nb.right  = cells[RIGHT_IDX];
            next_cells[i] = apply_rule(rule, nb);
        end
    end

endmodule

// File: rtl/ca_cell_reg.sv
module ca_cell_reg
    import ca_prng_pkg::*;
#(
    parameter int unsigned N_CELLS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cell_op_e           op,
    input  logic [N_CELLS-1:0] load_data,
    input  logic [N_CELLS-1:0] next_cells,
    output logic [N_CELLS-1:0] cells_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells_q <= '0;
        end else begin
            case (op)
                OP_LOAD: cells_q <= load_data;
                OP_STEP: cells_q <= next_cells;
                default: cells_q <= cells_q;
            endcase
        end
    end

endmodule

// File: rtl/ca_ring_prng.sv
module ca_ring_prng
    import ca_prng_pkg::*;
#(
    parameter int unsigned N_CELLS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seed_load,
    input  logic [N_CELLS-1:0] seed_data,
    input  logic               step_req,
    input  logic               rule_we,
    input  logic [7:0]         rule_data,
    output logic [N_CELLS-1:0] pattern
);

    rule_t              rule_q;
    cell_op_e           op;
    logic [N_CELLS-1:0] cells_q;
    logic [N_CELLS-1:0] next_cells;

    always_comb op = decode_op(seed_load, step_req);

    ca_rule_reg #(.RESET_RULE(RULE_30)) u_rule (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rule_we),
        .din    (rule_data),
        .rule_q (rule_q)
    );

    ca_next_gen #(.N_CELLS(N_CELLS)) u_next (
        .cells      (cells_q),
        .rule       (rule_q),
        .next_cells (next_cells)
    );

    ca_cell_reg #(.N_CELLS(N_CELLS)) u_cells (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .load_data  (seed_data),
        .next_cells (next_cells),
        .cells_q    (cells_q)
    );

    assign pattern = cells_q;

endmodule

// File: rtl/ca_prng_checker.sv
module ca_prng_checker
    import ca_prng_pkg::*;
#(
    parameter int unsigned N_CELLS = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               seed_load,
    input logic [N_CELLS-1:0] seed_data,
    input logic               step_req,
    input logic               rule_we,
    input logic [7:0]         rule_data,
    input logic [N_CELLS-1:0] pattern,
    input logic [7:0]         rule_q
);

    logic [N_CELLS-1:0] pat_d;
    logic [7:0]         rule_d;
    logic               rst_was_low = 1'b0;

    always_ff @(posedge clk) begin
        pat_d       <= pattern;
        rule_d      <= rule_q;
        rst_was_low <= !rst_n;
    end

    always_ff @(posedge clk) begin
        if (rst_was_low)
            AST_RESET_STATE: assert (pattern == '0 && rule_q == RULE_30); // R1
    end

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> pattern == $past(seed_data)); // R2

    AST_STEP_CELL0: assert property (@(posedge clk) disable iff (!rst_n)
        (step_req && !seed_load) |=>
            pattern[0] == rule_d[{pat_d[1], pat_d[0], pat_d[N_CELLS-1]}]); // R4

    AST_STEP_CELL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (step_req && !seed_load) |=>
            pattern[N_CELLS-1] == rule_d[{pat_d[0], pat_d[N_CELLS-1], pat_d[N_CELLS-2]}]); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !step_req) |=> $stable(pattern)); // R5

    AST_RULE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rule_we |=> rule_q == $past(rule_data)); // R7

    AST_ZERO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (step_req && !seed_load && pattern == '0 && !rule_q[0]) |=> pattern == '0); // R9

endmodule

bind ca_ring_prng ca_prng_checker #(.N_CELLS(N_CELLS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_load (seed_load),
    .seed_data (seed_data),
    .step_req  (step_req),
    .rule_we   (rule_we),
    .rule_data (rule_data),
    .pattern   (pattern),
    .rule_q    (rule_q)
);

// File: tb/ca_ring_prng_test.sv
`timescale 1ns/1ps
module ca_ring_prng_test;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         seed_load = 1'b0;
    logic [N-1:0] seed_data = '0;
    logic         step_req = 1'b0;
    logic         rule_we = 1'b0;
    logic [7:0]   rule_data = '0;
    logic [N-1:0] pattern;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [N-1:0] m_cells;
    logic [7:0]   m_rule;

    always #5 clk = ~clk;

    ca_ring_prng #(.N_CELLS(N)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .seed_data (seed_data),
        .step_req  (step_req),
        .rule_we   (rule_we),
        .rule_data (rule_data),
        .pattern   (pattern)
    );

    function automatic logic [N-1:0] gen(input logic [N-1:0] c, input logic [7:0] r);
        logic [N-1:0] o;
        for (int i = 0; i < N; i++) begin
            o[i] = r[{c[(i + 1) % N], c[i], c[(i + N - 1) % N]}];
        end
        return o;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle from a falling edge, then sample 1 ns after the rising edge
    task automatic cyc(input logic ld, input logic [N-1:0] d, input logic st,
                       input logic we, input logic [7:0] r);
        seed_load = ld; seed_data = d; step_req = st; rule_we = we; rule_data = r;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_cells = '0;
            m_rule  = 8'h1E;
        end else begin
            if (ld)      m_cells = d;
            else if (st) m_cells = gen(m_cells, m_rule);
            if (we)      m_rule = r;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(1'b0, '0, 1'b0, 1'b0, 8'h00);
        cyc(1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1, 8'hFF);
        rst_n = 1'b1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] keep;
        m_cells = '0;
        m_rule  = 8'h1E;
        void'($urandom(32'd20240607));
        @(negedge clk);
        do_reset();
        chk("R1 reset clears", pattern, '0);

        // R9: zero array is a fixed point
        for (int k = 0; k < 5; k++) cyc(1'b0, '0, 1'b1, 1'b0, 8'h00);
        chk("R9 zero stays zero", pattern, '0);

        // R2, R4 wrap with known rule-30 results
        cyc(1'b1, 32'h0000_0001, 1'b0, 1'b0, 8'h00);
        chk("R2 load", pattern, 32'h0000_0001);
        cyc(1'b0, '0, 1'b1, 1'b0, 8'h00);
        chk("R4 wrap low seed", pattern, 32'h8000_0003);
        cyc(1'b1, 32'h8000_0000, 1'b0, 1'b0, 8'h00);
        cyc(1'b0, '0, 1'b1, 1'b0, 8'h00);
        chk("R4 wrap high seed", pattern, 32'hC000_0001);

        // R3 several generations
        cyc(1'b1, 32'h1234_5678, 1'b0, 1'b0, 8'h00);
        for (int k = 0; k < 4; k++) begin
            cyc(1'b0, '0, 1'b1, 1'b0, 8'h00);
            chk("R3 step", pattern, m_cells);
        end

        // R5 hold
        keep = pattern;
        cyc(1'b0, 32'hDEAD_BEEF, 1'b0, 1'b0, 8'h00);
        chk("R5 hold", pattern, keep);

        // R6 load beats step
        cyc(1'b1, 32'hA5A5_0F0F, 1'b1, 1'b0, 8'h00);
        chk("R6 load priority", pattern, 32'hA5A5_0F0F);

        // R8 rule write alone
        cyc(1'b0, '0, 1'b0, 1'b1, 8'h5A);
        chk("R8 rule write no effect", pattern, 32'hA5A5_0F0F);

        // R7 step in the write cycle uses old rule (0x5A), next step the new (0x96)
        cyc(1'b0, '0, 1'b1, 1'b1, 8'h96);
        chk("R7 same-cycle old rule", pattern, gen(32'hA5A5_0F0F, 8'h5A));
        keep = pattern;
        cyc(1'b0, '0, 1'b1, 1'b0, 8'h00);
        chk("R7 next-cycle new rule", pattern, gen(keep, 8'h96));

        // R1 reset restores rule 30 after a rule change
        do_reset();
        chk("R1 reset clears again", pattern, '0);
        cyc(1'b1, 32'h0000_0001, 1'b0, 1'b0, 8'h00);
        cyc(1'b0, '0, 1'b1, 1'b0, 8'h00);
        chk("R1 rule 30 restored", pattern, 32'h8000_0003);

        // Random mix of loads, steps, holds and rule writes
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] sel;
            logic       ld, st, we;
            sel = 4'($urandom);
            ld = (sel == 4'd0);
            st = sel[0] | sel[1];
            we = (sel == 4'd7) || (sel == 4'd12);
            cyc(ld, $urandom, st, we, 8'($urandom));
            chk("R3 random", pattern, m_cells);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule